// File: doc/BRIEF.md
# Programmable Interrupt Source Router

The router sits between a set of interrupt source lines and a three-controller interrupt tree: one master controller with eight request inputs and two slave controllers. Each slave hangs off a fixed master input, slave 1 off input 2 and slave 2 off input 5. Every source owns an 8-bit map register. The low five bits of that register hold a routing code. The code selects one of 22 global priority ranks, the non-maskable interrupt line, or nothing at all. The ranks are not laid out in order across the controllers. Ranks 1 and 2 sit on master inputs 0 and 1. Ranks 3 to 10 fill slave 1. Ranks 11 and 12 sit on master inputs 3 and 4. Ranks 13 to 20 fill slave 2. Ranks 21 and 22 sit on master inputs 6 and 7.

Software programs the maps through a simple write port with a combinational read-back. The routing itself is purely combinational from the map contents, the source request lines, the two slave-present inputs and the two slave cascade inputs. Every request output is the OR of all sources routed to it.

When a slave is present, its cascade output, fed back in as an input, drives its master slot. When a slave is absent, the rank that would have been that slave's input 0 drives the master slot directly, and the ranks on the slave's inputs 1 to 7 go nowhere.

Top module: `irq_source_router`

## Requirements
- R1: After reset every map register reads 0x00. With both slave-present inputs low, every request output is then 0 whatever the source lines do.
- R2: A write to an implemented map address stores all 8 data bits and reads back unchanged on the next cycle. Only bits 4..0 take part in routing, so bits 7..5 have no effect on routing.
- R3: Codes 0 and 23 to 30 route the source nowhere: all 24 vector bits and the NMI output stay at their source-free value.
- R4: Code 31 drives `nmi_req` while the source is asserted, and touches no vector bit.
- R5: Codes 1, 2, 11, 12, 21 and 22 drive `master_req` bits 0, 1, 3, 4, 6 and 7 respectively.
- R6: With `slv1_present` high, codes 3 to 10 drive `slave1_req` bits 0 to 7 (bit = code - 3). `master_req[2]` then equals `slv1_cascade`.
- R7: With `slv2_present` high, codes 13 to 20 drive `slave2_req` bits 0 to 7 (bit = code - 13). `master_req[5]` then equals `slv2_cascade`.
- R8: With `slv1_present` low, code 3 drives `master_req[2]` directly, codes 4 to 10 reach no output, and `slave1_req` is 0.
- R9: With `slv2_present` low, code 13 drives `master_req[5]` directly, codes 14 to 20 reach no output, and `slave2_req` is 0.
- R10: Sources that share a code are OR-combined: the output is high while any one of them is asserted.
- R11: Outputs follow the source lines in the same cycle, with no clock edge needed. A new map takes effect from the clock edge that captures the write.
- R12: Writes to addresses at or above NUM_SRC are discarded, and reads there return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low synchronous reset of the map registers |
| reg_wr | input | 1 | Write strobe for the map port |
| reg_addr | input | ADDR_W | Map register index (source number) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read-back of the addressed map |
| src_req | input | NUM_SRC | Interrupt request line of each source |
| slv1_present | input | 1 | Slave 1 exists in the cascade |
| slv2_present | input | 1 | Slave 2 exists in the cascade |
| slv1_cascade | input | 1 | Cascade request from slave 1 toward master input 2 |
| slv2_cascade | input | 1 | Cascade request from slave 2 toward master input 5 |
| master_req | output | 8 | Request vector to the master controller |
| slave1_req | output | 8 | Request vector to slave 1 |
| slave2_req | output | 8 | Request vector to slave 2 |
| nmi_req | output | 1 | Non-maskable interrupt request |

## Verification
The bench builds the router with NUM_SRC = 6, which leaves ADDR_W at 3. Two addresses, 6 and 7, are therefore decodable but not implemented, and this brings the discard-and-read-zero rule of R12 within reach. Six sources are enough to walk all 32 codes on one source under each combination of slave-present inputs, and to pile several sources onto one rank for the OR rule. The cascade inputs are driven both ways while a slave is present, so the hand-over of the master slots between direct and cascade drive is exercised in both directions.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
    // register and code geometry
    localparam int REG_W   = 8;
    localparam int CODE_W  = 5;
    localparam int NUM_CH  = 22;            // priority ranks 1..22
    localparam int VEC_W   = 8;             // inputs per controller
    localparam logic [CODE_W-1:0] CODE_NMI = 5'd31;

    // rank indices (rank - 1) that sit on the slave-attach master inputs
    localparam int S1_BASE = 2;             // rank 3  -> slave 1 input 0
    localparam int S2_BASE = 12;            // rank 13 -> slave 2 input 0

    // master input positions of the two slaves
    localparam int M_SLOT_S1 = 2;
    localparam int M_SLOT_S2 = 5;
endpackage

// File: rtl/irq_map_regs.sv
module irq_map_regs
    import irq_route_pkg::*;
#(
    parameter int NUM_SRC = 16,
    parameter int ADDR_W  = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [REG_W-1:0]               wdata,
    output logic [REG_W-1:0]               rdata,
    output logic [NUM_SRC-1:0][REG_W-1:0]  maps
);
    logic addr_ok;

    assign addr_ok = (int'(addr) < NUM_SRC);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            maps <= '0;
        end else if (wr_en && addr_ok) begin
            maps[addr] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr_ok) begin
            rdata = maps[addr];
        end
    end
endmodule

// File: rtl/irq_code_decode.sv
module irq_code_decode
    import irq_route_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  logic              req,
    output logic [NUM_CH-1:0] ch_hit,
    output logic              nmi_hit
);
    // one rank bit per code 1..22; every other code but 31 selects none
    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            ch_hit[c] = req && (code == CODE_W'(c + 1));
        end
        nmi_hit = req && (code == CODE_NMI);
    end
endmodule

// File: rtl/irq_vector_build.sv
module irq_vector_build
    import irq_route_pkg::*;
(
    input  logic [NUM_CH-1:0] ch_req,
    input  logic              slv1_present,
    input  logic              slv2_present,
    input  logic              slv1_cascade,
    input  logic              slv2_cascade,
    output logic [VEC_W-1:0]  master_req,
    output logic [VEC_W-1:0]  slave1_req,
    output logic [VEC_W-1:0]  slave2_req
);
    // slave vectors carry ranks only when the slave exists
    for (genvar i = 0; i < VEC_W; i++) begin : g_slave
        assign slave1_req[i] = slv1_present && ch_req[S1_BASE + i];
        assign slave2_req[i] = slv2_present && ch_req[S2_BASE + i];
    end

    always_comb begin
        master_req[0] = ch_req[0];
        master_req[1] = ch_req[1];
        master_req[M_SLOT_S1] = slv1_present ? slv1_cascade : ch_req[S1_BASE];
        master_req[3] = ch_req[10];
        master_req[4] = ch_req[11];
        master_req[M_SLOT_S2] = slv2_present ? slv2_cascade : ch_req[S2_BASE];
        master_req[6] = ch_req[20];
        master_req[7] = ch_req[21];
    end
endmodule

// File: rtl/irq_source_router.sv
module irq_source_router
    import irq_route_pkg::*;
#(
    parameter int NUM_SRC = 16,
    parameter int ADDR_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [7:0]         reg_wdata,
    output logic [7:0]         reg_rdata,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic               slv1_present,
    input  logic               slv2_present,
    input  logic               slv1_cascade,
    input  logic               slv2_cascade,
    output logic [7:0]         master_req,
    output logic [7:0]         slave1_req,
    output logic [7:0]         slave2_req,
    output logic               nmi_req
);
    logic [NUM_SRC-1:0][REG_W-1:0]  maps;
    logic [NUM_SRC-1:0][NUM_CH-1:0] src_ch;
    logic [NUM_SRC-1:0]             src_nmi;
    logic [NUM_CH-1:0]              ch_req;

    irq_map_regs #(
        .NUM_SRC (NUM_SRC),
        .ADDR_W  (ADDR_W)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .maps  (maps)
    );

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        irq_code_decode u_dec (
            .code    (maps[s][CODE_W-1:0]),
            .req     (src_req[s]),
            .ch_hit  (src_ch[s]),
            .nmi_hit (src_nmi[s])
        );
    end

    // wired-OR of all sources per rank
    always_comb begin
        ch_req = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            ch_req = ch_req | src_ch[s];
        end
    end

    assign nmi_req = |src_nmi;

    irq_vector_build u_vec (
        .ch_req       (ch_req),
        .slv1_present (slv1_present),
        .slv2_present (slv2_present),
        .slv1_cascade (slv1_cascade),
        .slv2_cascade (slv2_cascade),
        .master_req   (master_req),
        .slave1_req   (slave1_req),
        .slave2_req   (slave2_req)
    );
endmodule

// File: rtl/irq_source_router_chk.sv
module irq_source_router_chk #(
    parameter int NUM_SRC = 16,
    parameter int ADDR_W  = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_wr,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [7:0]         reg_wdata,
    input logic [7:0]         reg_rdata,
    input logic [NUM_SRC-1:0] src_req,
    input logic               slv1_present,
    input logic               slv2_present,
    input logic               slv1_cascade,
    input logic               slv2_cascade,
    input logic [7:0]         master_req,
    input logic [7:0]         slave1_req,
    input logic [7:0]         slave2_req,
    input logic               nmi_req
);
    // R2: a write to an implemented address reads back next cycle
    assert_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (int'(reg_addr) < NUM_SRC)) |=>
            (!$stable(reg_addr) || reg_rdata == $past(reg_wdata)));

    // R4 / R10: no NMI without some source asserted
    assert_nmi_needs_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req |-> (src_req != '0));

    // R6: slave 1 present hands master slot 2 to its cascade
    assert_cascade1_R6: assert property (@(posedge clk) disable iff (!rst_n)
        slv1_present |-> (master_req[2] == slv1_cascade));

    // R7: slave 2 present hands master slot 5 to its cascade
    assert_cascade2_R7: assert property (@(posedge clk) disable iff (!rst_n)
        slv2_present |-> (master_req[5] == slv2_cascade));

    // R8: absent slave 1 gets nothing
    assert_slave1_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !slv1_present |-> (slave1_req == 8'h00));

    // R9: absent slave 2 gets nothing
    assert_slave2_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !slv2_present |-> (slave2_req == 8'h00));

    // R11: with no source asserted only the cascade slots may be high
    assert_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (src_req == '0) |->
            (slave1_req == 8'h00 && slave2_req == 8'h00 && !nmi_req &&
             (master_req & 8'hDB) == 8'h00));
endmodule

bind irq_source_router irq_source_router_chk #(
    .NUM_SRC (NUM_SRC),
    .ADDR_W  (ADDR_W)
) u_chk (.*);

// File: tb/irq_source_router_bench.sv
module irq_source_router_bench;
    localparam int NSRC = 6;
    localparam int AW   = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            reg_wr = 1'b0;
    logic [AW-1:0]   reg_addr = '0;
    logic [7:0]      reg_wdata = '0;
    logic [7:0]      reg_rdata;
    logic [NSRC-1:0] src_req = '0;
    logic            slv1_present = 1'b0;
    logic            slv2_present = 1'b0;
    logic            slv1_cascade = 1'b0;
    logic            slv2_cascade = 1'b0;
    logic [7:0]      master_req, slave1_req, slave2_req;
    logic            nmi_req;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;   // 125 MHz

    irq_source_router #(.NUM_SRC(NSRC)) u_irq_source_router (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_req(src_req),
        .slv1_present(slv1_present), .slv2_present(slv2_present),
        .slv1_cascade(slv1_cascade), .slv2_cascade(slv2_cascade),
        .master_req(master_req), .slave1_req(slave1_req),
        .slave2_req(slave2_req), .nmi_req(nmi_req)
    );

    // outputs packed as {nmi, slave2, slave1, master}
    function automatic logic [24:0] outs();
        return {nmi_req, slave2_req, slave1_req, master_req};
    endfunction

    // expected outputs for one asserted source with the given code
    function automatic logic [24:0] model(input int code, input bit p1, input bit p2,
                                          input bit c1, input bit c2);
        logic [7:0] m = '0, s1 = '0, s2 = '0;
        logic n = 1'b0;
        if (p1) m[2] = c1;
        if (p2) m[5] = c2;
        case (code)
            1:  m[0] = 1'b1;
            2:  m[1] = 1'b1;
            11: m[3] = 1'b1;
            12: m[4] = 1'b1;
            21: m[6] = 1'b1;
            22: m[7] = 1'b1;
            31: n = 1'b1;
            default: begin
                if (code >= 3 && code <= 10) begin
                    if (p1) s1[code-3] = 1'b1;
                    else if (code == 3) m[2] = 1'b1;
                end
                if (code >= 13 && code <= 20) begin
                    if (p2) s2[code-13] = 1'b1;
                    else if (code == 13) m[5] = 1'b1;
                end
            end
        endcase
        return {n, s2, s1, m};
    endfunction

    task automatic check(input string tag, input logic [24:0] got, input logic [24:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr_map(input int a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_check(input string tag, input int a, input logic [7:0] exp);
        @(negedge clk);
        reg_addr = AW'(a);
        #1;
        check(tag, {17'h0, reg_rdata}, {17'h0, exp});
    endtask

    task automatic clear_maps();
        for (int a = 0; a < NSRC; a++) wr_map(a, 8'h00);
        src_req = '0;
    endtask

    // walk every code on source 0 under one slave configuration
    task automatic sweep(input string tag, input bit p1, input bit p2);
        slv1_present = p1; slv2_present = p2;
        slv1_cascade = 1'b0; slv2_cascade = 1'b0;
        for (int code = 0; code < 32; code++) begin
            wr_map(0, 8'(code));
            src_req = 6'b000001;
            #1;
            check(tag, outs(), model(code, p1, p2, 1'b0, 1'b0));
            src_req = '0;
            #1;
            check(tag, outs(), model(0, p1, p2, 1'b0, 1'b0));
        end
    endtask

    task automatic test_reset();
        for (int a = 0; a < NSRC; a++) rd_check("R1 map reset", a, 8'h00);
        src_req = '1;
        #1;
        check("R1 outputs after reset", outs(), 25'h0);
        src_req = '0;
    endtask

    task automatic test_regs();
        wr_map(1, 8'hE5);
        rd_check("R2 readback", 1, 8'hE5);
        wr_map(2, 8'h3A);
        rd_check("R2 readback second", 2, 8'h3A);
        rd_check("R2 neighbour kept", 1, 8'hE5);
        // reserved bits do not alter routing: 0xE1 routes like code 1
        wr_map(1, 8'hE1);
        src_req = 6'b000010;
        #1;
        check("R2 reserved bits ignored", outs(), model(1, 0, 0, 0, 0));
        src_req = '0;
        // unimplemented addresses
        wr_map(6, 8'h5A);
        rd_check("R12 unused addr 6", 6, 8'h00);
        wr_map(7, 8'hFF);
        rd_check("R12 unused addr 7", 7, 8'h00);
        for (int a = 0; a < NSRC; a++)
            rd_check("R12 no alias", a, (a == 1) ? 8'hE1 : (a == 2) ? 8'h3A : 8'h00);
        clear_maps();
    endtask

    task automatic test_direct_and_disable();
        sweep("R3 R4 R5 R8 R9 both slaves absent", 1'b0, 1'b0);
        clear_maps();
    endtask

    task automatic test_slaves_present();
        sweep("R5 R6 R7 both slaves present", 1'b1, 1'b1);
        sweep("R6 R9 slave1 only", 1'b1, 1'b0);
        sweep("R7 R8 slave2 only", 1'b0, 1'b1);
        clear_maps();
    endtask

    task automatic test_cascade();
        slv1_present = 1'b1; slv2_present = 1'b1;
        wr_map(0, 8'd3);
        wr_map(1, 8'd13);
        src_req = 6'b000011;
        slv1_cascade = 1'b1; slv2_cascade = 1'b0;
        #1;
        check("R6 cascade1 high", outs(), {1'b0, 8'h01, 8'h01, 8'h04});
        slv1_cascade = 1'b0; slv2_cascade = 1'b1;
        #1;
        check("R7 cascade2 high", outs(), {1'b0, 8'h01, 8'h01, 8'h20});
        // remove the slaves: direct drive of the master slots
        slv1_present = 1'b0; slv2_present = 1'b0;
        #1;
        check("R8 R9 bypass direct slots", outs(), {1'b0, 8'h00, 8'h00, 8'h24});
        slv2_cascade = 1'b0;
        clear_maps();
    endtask

    task automatic test_or();
        wr_map(2, 8'd1);
        wr_map(4, 8'd1);
        wr_map(5, 8'd31);
        wr_map(3, 8'd31);
        src_req = 6'b000100;
        #1; check("R10 first of pair", outs(), model(1, 0, 0, 0, 0));
        src_req = 6'b010000;
        #1; check("R10 second of pair", outs(), model(1, 0, 0, 0, 0));
        src_req = 6'b010100;
        #1; check("R10 both of pair", outs(), model(1, 0, 0, 0, 0));
        src_req = 6'b101000;
        #1; check("R10 R4 shared nmi", outs(), model(31, 0, 0, 0, 0));
        src_req = 6'b100000;
        #1; check("R10 R4 one nmi", outs(), model(31, 0, 0, 0, 0));
        src_req = '0;
        clear_maps();
    endtask

    task automatic test_timing();
        // map change becomes visible after the capturing edge only
        wr_map(0, 8'd2);
        src_req = 6'b000001;
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 8'd22;
        #1;
        check("R11 old map before edge", outs(), model(2, 0, 0, 0, 0));
        @(posedge clk);
        #1;
        reg_wr = 1'b0;
        check("R11 new map after edge", outs(), model(22, 0, 0, 0, 0));
        // request change with no edge in between
        @(negedge clk);
        src_req = '0;
        #1;
        check("R11 same-cycle drop", outs(), 25'h0);
        src_req = 6'b000001;
        #1;
        check("R11 same-cycle rise", outs(), model(22, 0, 0, 0, 0));
        clear_maps();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_regs();
        test_direct_and_disable();
        test_slaves_present();
        test_cascade();
        test_or();
        test_timing();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule